// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command bus of a synchronous DRAM from reset until the memory is ready for normal traffic. After reset is released it holds the bus at NOP for a programmable settling time; 5000 cycles is 100 µs at 50 MHz. It then issues a precharge of every bank and two auto-refresh commands. Last comes a mode-register load whose word is built from four configuration fields. Every command is followed by NOPs for a programmable gap. Once the gap after the mode load has passed, a completion flag rises. A memory controller hands the bus over to normal operation when it sees that flag.

All gaps are parameters in clock cycles, so the sequencer can be matched to any clock rate and any timing grade. Every output is driven from a register. Reset may arrive at any time, and it restarts the whole script from the settling wait.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is high, and for the first T_WAIT cycles after the last reset edge, the command {cs_n,ras_n,cas_n,we_n} is NOP (0111) and init_done is low.
- R2: Exactly T_WAIT cycles after the last reset edge, one PRECHARGE (0010) is issued with addr bit 10 high, every other addr bit low and ba zero.
- R3: The first AUTO REFRESH (0001) is issued exactly T_RP cycles after the precharge.
- R4: The second AUTO REFRESH is issued exactly T_RFC cycles after the first. No other refresh is issued.
- R5: LOAD MODE (0000) is issued exactly T_RFC cycles after the second refresh, with ba zero. Its addr carries the fields at these positions: burst length in bits 2:0, interleaved burst type in bit 3, CAS latency in bits 6:4, single-write burst mode in bit 9.
- R6: During LOAD MODE, addr bits 8:7 and every bit from 10 upward are zero, whatever the field inputs are.
- R7: In every cycle of the script that does not issue one of the four commands above, the command is NOP.
- R8: init_done rises exactly T_MRD cycles after LOAD MODE. It then stays high with the bus at NOP until the next reset.
- R9: A reset asserted at any point, including the cycle in which a command would be issued, forces NOP and a low init_done. It restarts the full script with the same timing.
- R10: In every NOP cycle, addr and ba are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; restarts the script |
| cfg_burst_len | input | 3 | Burst length code placed in mode bits 2:0 |
| cfg_burst_interleave | input | 1 | Burst type placed in mode bit 3 (1 = interleaved) |
| cfg_cas_lat | input | 3 | CAS latency code placed in mode bits 6:4 |
| cfg_wr_single | input | 1 | Write burst mode placed in mode bit 9 (1 = single writes) |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus: A10 flag for precharge, mode word for mode load |
| ba | output | BANK_W | Bank select, zero throughout the script |
| init_done | output | 1 | High once the script has completed |

## Verification
A reset can land in the same cycle in which a step of the script would issue its command. The bench provokes this by raising reset on the edge where LOAD MODE is due, and again in the middle of the settling wait and after completion. At each of those edges the reference model expects NOP and a low completion flag, and it expects the full script to replay with unchanged spacing. Field inputs with every bit set are used in a replay to show that the forced-zero positions of the mode word stay clear.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // Command encodings on {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LOAD_MODE = 4'b0000,
    CMD_REFRESH   = 4'b0001,
    CMD_PRECHARGE = 4'b0010,
    CMD_NOP       = 4'b0111
  } sdram_cmd_e;

  // Steps of the power-up script, in issue order
  typedef enum logic [2:0] {
    STEP_SETTLE,
    STEP_PRECHARGE,
    STEP_REFRESH_A,
    STEP_REFRESH_B,
    STEP_LOAD_MODE,
    STEP_READY
  } init_step_e;

  typedef struct packed {
    logic       wr_single;
    logic [2:0] cas_lat;
    logic       interleave;
    logic [2:0] burst_len;
  } mode_fields_t;

  // Bit position of the all-banks flag during precharge
  localparam int unsigned ALL_BANKS_BIT = 10;

  function automatic sdram_cmd_e step_command(init_step_e s);
    case (s)
      STEP_PRECHARGE: return CMD_PRECHARGE;
      STEP_REFRESH_A: return CMD_REFRESH;
      STEP_REFRESH_B: return CMD_REFRESH;
      STEP_LOAD_MODE: return CMD_LOAD_MODE;
      default:        return CMD_NOP;
    endcase
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
// Down-counter that measures the gap of the current script step.
module sdram_init_timer #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_W'(RST_VAL);
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_mode.sv
// Packs the configuration fields into the mode-register word.
module sdram_init_mode
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  mode_fields_t      fields,
  output logic [ADDR_W-1:0] word
);

  localparam int unsigned LOW_W = 10;

  assign word[2:0] = fields.burst_len;
  assign word[3]   = fields.interleave;
  assign word[6:4] = fields.cas_lat;
  assign word[8:7] = 2'b00;            // standard operating mode
  assign word[9]   = fields.wr_single;

  generate
    for (genvar i = LOW_W; i < ADDR_W; i++) begin : g_rsvd
      assign word[i] = 1'b0;           // reserved / must-be-low bits
    end
  endgenerate

endmodule

// File: rtl/sdram_init_drive.sv
// Registered command/address stage of the sequencer.
module sdram_init_drive
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  init_step_e        step,
  input  logic [ADDR_W-1:0] mode_word,
  output logic [3:0]        cmd,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << ALL_BANKS_BIT;

  sdram_cmd_e        cmd_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst || !issue) begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
    end else begin
      cmd_q <= step_command(step);
      case (step)
        STEP_PRECHARGE: addr_q <= ALL_BANKS;
        STEP_LOAD_MODE: addr_q <= mode_word;
        default:        addr_q <= '0;
      endcase
    end
  end

  assign cmd  = cmd_q;
  assign addr = addr_q;

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned T_WAIT = 5000,  // settling wait, cycles
  parameter int unsigned T_RP   = 3,     // precharge to refresh
  parameter int unsigned T_RFC  = 10,    // refresh to next command
  parameter int unsigned T_MRD  = 2      // mode load to ready
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_burst_interleave,
  input  logic [2:0]        cfg_cas_lat,
  input  logic              cfg_wr_single,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] ba,
  output logic              init_done
);

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  localparam int unsigned MAX_GAP = max2(max2(T_WAIT, T_RP), max2(T_RFC, T_MRD));
  localparam int unsigned CNT_W   = $clog2(MAX_GAP + 1);
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] LD_RFC = CNT_W'(T_RFC - 1);
  localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(T_MRD - 1);

  init_step_e        step_q, step_nx;
  logic              gap_over, advance, done_q;
  logic [CNT_W-1:0]  gap_load;
  logic [ADDR_W-1:0] mode_word;
  logic [3:0]        cmd_bits;
  mode_fields_t      fields;

  assign fields = '{wr_single:  cfg_wr_single,
                    cas_lat:    cfg_cas_lat,
                    interleave: cfg_burst_interleave,
                    burst_len:  cfg_burst_len};

  always_comb begin
    case (step_q)
      STEP_SETTLE:    begin step_nx = STEP_PRECHARGE; gap_load = LD_RP;  end
      STEP_PRECHARGE: begin step_nx = STEP_REFRESH_A; gap_load = LD_RFC; end
      STEP_REFRESH_A: begin step_nx = STEP_REFRESH_B; gap_load = LD_RFC; end
      STEP_REFRESH_B: begin step_nx = STEP_LOAD_MODE; gap_load = LD_MRD; end
      default:        begin step_nx = STEP_READY;     gap_load = '0;     end
    endcase
  end

  assign advance = gap_over && (step_q != STEP_READY);

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= STEP_SETTLE;
      done_q <= 1'b0;
    end else if (advance) begin
      step_q <= step_nx;
      done_q <= (step_nx == STEP_READY);
    end
  end

  sdram_init_timer #(
    .CNT_W   (CNT_W),
    .RST_VAL (T_WAIT - 1)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (advance),
    .load_val (gap_load),
    .expired  (gap_over)
  );

  sdram_init_mode #(
    .ADDR_W (ADDR_W)
  ) u_mode (
    .fields (fields),
    .word   (mode_word)
  );

  sdram_init_drive #(
    .ADDR_W (ADDR_W)
  ) u_drive (
    .clk       (clk),
    .rst       (rst),
    .issue     (advance),
    .step      (step_nx),
    .mode_word (mode_word),
    .cmd       (cmd_bits),
    .addr      (addr)
  );

  assign {cs_n, ras_n, cas_n, we_n} = cmd_bits;
  assign ba        = '0;
  assign init_done = done_q;

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned BANK_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [BANK_W-1:0] ba,
  input logic              init_done
);

  logic [3:0] c;
  assign c = {cs_n, ras_n, cas_n, we_n};

  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (c == 4'b0111 || c == 4'b0010 || c == 4'b0001 || c == 4'b0000)); // R7

  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (rst)
    (c == 4'b0010) |-> (addr == (ADDR_W'(1) << 10) && ba == '0)); // R2

  AST_MODE_RSVD_LOW: assert property (@(posedge clk) disable iff (rst)
    (c == 4'b0000) |-> (addr[8:7] == 2'b00 && (addr >> 10) == '0 && ba == '0)); // R6

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done); // R8

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (c == 4'b0111)); // R8

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (c == 4'b0111 && !init_done)); // R9

  AST_IDLE_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (c == 4'b0111) |-> (addr == '0 && ba == '0)); // R10

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .ADDR_W (ADDR_W),
  .BANK_W (BANK_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .addr      (addr),
  .ba        (ba),
  .init_done (init_done)
);

// File: tb/sdram_init_seq_tb.sv
`timescale 1ns/1ps
module sdram_init_seq_tb;

  localparam int AW = 13;
  localparam int BW = 2;
  localparam int W   = 20;
  localparam int RP  = 3;
  localparam int RFC = 5;
  localparam int MRD = 2;
  localparam int T_PRE  = W;
  localparam int T_REF1 = W + RP;
  localparam int T_REF2 = W + RP + RFC;
  localparam int T_LMR  = W + RP + 2 * RFC;
  localparam int T_DONE = T_LMR + MRD;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] bl = 3'd0;
  logic bt = 1'b0;
  logic [2:0] cl = 3'd0;
  logic wb = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, done;
  logic [AW-1:0] addr;
  logic [BW-1:0] ba;

  int n_tests = 0;
  int n_fail  = 0;
  int t = 0;
  bit in_rst = 1'b1;
  bit restarted = 1'b0;
  bit chk_en = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sdram_init_seq #(
    .ADDR_W (AW), .BANK_W (BW), .T_WAIT (W), .T_RP (RP), .T_RFC (RFC), .T_MRD (MRD)
  ) u_dut (
    .clk (clk), .rst (rst),
    .cfg_burst_len (bl), .cfg_burst_interleave (bt),
    .cfg_cas_lat (cl), .cfg_wr_single (wb),
    .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
    .addr (addr), .ba (ba), .init_done (done)
  );

  // Reference model: cycle index since the last reset edge
  always @(posedge clk) begin
    if (rst) begin
      t <= 0;
      in_rst <= 1'b1;
    end else begin
      t <= t + 1;
      in_rst <= 1'b0;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: cycle %0d actual %h expected %h", tag, t, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      logic [3:0] e_cmd;
      logic [AW-1:0] e_addr;
      logic e_done;
      string tag;
      e_cmd = 4'b0111; e_addr = '0; e_done = 1'b0;
      if (in_rst) tag = "R9";
      else if (t < T_PRE) tag = restarted ? "R9" : "R1";
      else tag = "R7";
      if (!in_rst) begin
        if (t == T_PRE)  begin e_cmd = 4'b0010; e_addr = AW'(1) << 10; tag = "R2"; end
        if (t == T_REF1) begin e_cmd = 4'b0001; tag = "R3"; end
        if (t == T_REF2) begin e_cmd = 4'b0001; tag = "R4"; end
        if (t == T_LMR)  begin
          e_cmd = 4'b0000; tag = "R5";
          e_addr = '0;
          e_addr[2:0] = bl; e_addr[3] = bt; e_addr[6:4] = cl; e_addr[9] = wb;
        end
        if (t >= T_DONE) begin e_done = 1'b1; tag = "R8"; end
      end
      check(tag, {28'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, e_cmd});
      check(tag, {31'd0, done}, {31'd0, e_done});
      check(tag, 32'(addr), 32'(e_addr));
      if (e_cmd == 4'b0111) check("R10", 32'({addr, ba}), 32'd0);
      if (e_cmd == 4'b0000) check("R6", {29'd0, addr[12:10]} | {30'd0, addr[8:7]}, 32'd0);
      if (e_cmd == 4'b0000) check("R5", 32'(ba), 32'd0);
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_reset(int n);
    rst = 1'b1;
    cycles(n);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    chk_en = 1'b1;
    // Run 1: reset state, then a full script with ordinary fields
    bl = 3'b011; bt = 1'b0; cl = 3'b010; wb = 1'b0;
    cycles(4);
    rst = 1'b0;
    cycles(T_DONE + 15);
    // Run 2: reset in the middle of the settling wait, all-ones fields
    restarted = 1'b1;
    pulse_reset(2);
    cycles(10);
    rst = 1'b1;
    bl = 3'b111; bt = 1'b1; cl = 3'b111; wb = 1'b1;
    cycles(2);
    rst = 1'b0;
    cycles(T_DONE + 10);
    // Run 3: reset lands on the edge where LOAD MODE is due
    bl = 3'b000; bt = 1'b1; cl = 3'b011; wb = 1'b0;
    pulse_reset(1);
    while (t != T_LMR - 1) @(negedge clk);
    pulse_reset(2);
    cycles(T_DONE + 10);
    // Run 4: reset long after completion, then one more full script
    bl = 3'b010; bt = 1'b0; cl = 3'b010; wb = 1'b1;
    cycles(30);
    pulse_reset(3);
    cycles(T_DONE + 8);
    chk_en = 1'b0;
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule